// File: doc/BRIEF.md
# Memory Region Type Predictor

This block guesses, for every memory access, which class of memory the access will land in: tightly coupled memory (TCM), cacheable memory or non-cacheable memory. It keeps one guess for instruction fetches and a separate one for data accesses. Each guess is simply the class seen by the previous accepted access on that side. When an access arrives, the block decodes its attributes into a class and compares that class with the guess for its side. A correct guess costs nothing. A wrong guess costs a fixed penalty of `PENALTY` cycles, and the guess then takes on the new class.

Each side has its own valid/ready access port. An access is taken on a rising clock edge where `valid` and `ready` are both high. `ready` is the inverse of that side's `busy`, so a side under penalty applies back-pressure. A requester must hold its access and its attributes steady until the access is taken. The remaining penalty and the current guess are visible on plain status outputs.

Data accesses aimed at instruction TCM are a special case. They always pay the penalty and never change the data-side guess.

Top module: `region_predictor`

## Requirements
- R1: After reset, both `i_pred` and `d_pred` read 2'b01 (cacheable), both busy outputs are low and both stall counts are zero. The class encoding is 2'b00 TCM, 2'b01 cacheable, 2'b10 non-cacheable.
- R2: On the instruction side, `i_itcm`=1 decodes to TCM. Otherwise `i_cbit`=1 decodes to cacheable and `i_cbit`=0 decodes to non-cacheable.
- R3: On the data side, `d_dtcm`=1 decodes to TCM. Otherwise `d_attr`[1]=1 (write-through 2'b10, write-back 2'b11) decodes to cacheable, and `d_attr`[1]=0 (2'b00 and 2'b01, the two uncached encodings) decodes to non-cacheable.
- R4: When a taken access decodes to a class other than its side's guess, the side's stall count reads `PENALTY` (2) in the cycle after the edge and counts down by one per cycle to zero. Busy is high while the count is non-zero, and the guess shows the new class from the cycle after the edge.
- R5: A taken access whose class equals the guess leaves the stall count at zero, busy low and the guess unchanged.
- R6: On the data side, a write-back access that follows a write-through access causes no stall.
- R7: A data access with `d_itcm`=1 always causes a `PENALTY`-cycle stall and leaves `d_pred` unchanged. This holds even when it repeats and even when `d_dtcm` is also set.
- R8: `ready` is low while its side is busy. An access presented then is not taken: it neither reloads the stall count nor changes the guess.
- R9: The two sides are independent. A stall on one side changes neither the other side's ready, its stall count nor its guess.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Instruction access present |
| i_ready | output | 1 | Instruction side can take an access |
| i_itcm | input | 1 | Fetch targets instruction TCM |
| i_cbit | input | 1 | Page-table cacheable bit of the fetch |
| i_stall | output | CW | Remaining instruction-side penalty cycles |
| i_busy | output | 1 | Instruction side is under penalty |
| i_pred | output | 2 | Instruction-side guessed class |
| d_valid | input | 1 | Data access present |
| d_ready | output | 1 | Data side can take an access |
| d_dtcm | input | 1 | Access targets data TCM |
| d_itcm | input | 1 | Data access targets instruction TCM |
| d_attr | input | 2 | Cache policy: 00/01 uncached, 10 write-through, 11 write-back |
| d_stall | output | CW | Remaining data-side penalty cycles |
| d_busy | output | 1 | Data side is under penalty |
| d_pred | output | 2 | Data-side guessed class |

## Verification
The assertions assume that a requester holds its attributes steady while `valid` is high. They also take the decode priority as fixed: instruction TCM first, then data TCM, then the cache policy bits. That lets the checker decode the class again on its own and judge whether a stall was due. The bench drives every input on the falling edge, raises `valid` for exactly one cycle per access, and only presents accesses against busy sides on purpose, to show that they are ignored. It never changes attributes in the middle of an access.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    RG_TCM   = 2'b00,
    RG_CACHE = 2'b01,
    RG_NONC  = 2'b10
  } region_e;
endpackage

// File: rtl/rp_ifetch_decode.sv
module rp_ifetch_decode
  import rp_pkg::*;
(
  input  logic    itcm,
  input  logic    cbit,
  output region_e region
);
  always_comb begin
    if (itcm)      region = RG_TCM;
    else if (cbit) region = RG_CACHE;
    else           region = RG_NONC;
  end
endmodule

// File: rtl/rp_data_decode.sv
module rp_data_decode
  import rp_pkg::*;
(
  input  logic       dtcm,
  input  logic       itcm,
  input  logic [1:0] attr,
  output region_e    region,
  output logic       force_stall
);
  // An instruction-TCM target always pays the penalty and never trains the guess.
  assign force_stall = itcm;

  always_comb begin
    if (dtcm)         region = RG_TCM;
    else if (attr[1]) region = RG_CACHE;   // write-through or write-back
    else              region = RG_NONC;    // either uncached encoding
  end
endmodule

// File: rtl/rp_side.sv
module rp_side
  import rp_pkg::*;
#(
  parameter int PENALTY = 2,
  localparam int CW = $clog2(PENALTY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  region_e       acc_region,
  input  logic          force_stall,
  output logic          acc_ready,
  output logic [CW-1:0] stall_cnt,
  output logic          busy,
  output region_e       pred
);
  logic take;
  logic miss;

  assign busy      = (stall_cnt != '0);
  assign acc_ready = ~busy;
  assign take      = acc_valid & acc_ready;
  assign miss      = take & (force_stall | (acc_region != pred));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0;
      pred      <= RG_CACHE;
    end else begin
      if (miss)      stall_cnt <= CW'(PENALTY);
      else if (busy) stall_cnt <= stall_cnt - 1'b1;
      if (take && !force_stall) pred <= acc_region;
    end
  end
endmodule

// File: rtl/region_predictor.sv
module region_predictor
  import rp_pkg::*;
#(
  parameter int PENALTY = 2,
  localparam int CW = $clog2(PENALTY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_valid,
  output logic          i_ready,
  input  logic          i_itcm,
  input  logic          i_cbit,
  output logic [CW-1:0] i_stall,
  output logic          i_busy,
  output logic [1:0]    i_pred,
  input  logic          d_valid,
  output logic          d_ready,
  input  logic          d_dtcm,
  input  logic          d_itcm,
  input  logic [1:0]    d_attr,
  output logic [CW-1:0] d_stall,
  output logic          d_busy,
  output logic [1:0]    d_pred
);
  region_e i_region, d_region, i_guess, d_guess;
  logic    d_force;

  rp_ifetch_decode u_idec (
    .itcm(i_itcm), .cbit(i_cbit), .region(i_region)
  );

  rp_data_decode u_ddec (
    .dtcm(d_dtcm), .itcm(d_itcm), .attr(d_attr),
    .region(d_region), .force_stall(d_force)
  );

  rp_side #(.PENALTY(PENALTY)) u_iside (
    .clk(clk), .rst_n(rst_n), .acc_valid(i_valid), .acc_region(i_region),
    .force_stall(1'b0), .acc_ready(i_ready), .stall_cnt(i_stall),
    .busy(i_busy), .pred(i_guess)
  );

  rp_side #(.PENALTY(PENALTY)) u_dside (
    .clk(clk), .rst_n(rst_n), .acc_valid(d_valid), .acc_region(d_region),
    .force_stall(d_force), .acc_ready(d_ready), .stall_cnt(d_stall),
    .busy(d_busy), .pred(d_guess)
  );

  assign i_pred = i_guess;
  assign d_pred = d_guess;
endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
  parameter int PENALTY = 2,
  localparam int CW = $clog2(PENALTY + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          i_valid,
  input logic          i_ready,
  input logic          i_itcm,
  input logic          i_cbit,
  input logic [CW-1:0] i_stall,
  input logic          i_busy,
  input logic [1:0]    i_pred,
  input logic          d_valid,
  input logic          d_ready,
  input logic          d_dtcm,
  input logic          d_itcm,
  input logic [1:0]    d_attr,
  input logic [CW-1:0] d_stall,
  input logic          d_busy,
  input logic [1:0]    d_pred
);
  assert_reset_pred_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (i_pred == 2'b01 && d_pred == 2'b01 && !i_busy && !d_busy));

  assert_i_tcm_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ready && i_itcm && i_pred == 2'b00) |=> (i_stall == '0));

  assert_d_nonc_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_ready && !d_itcm && !d_dtcm && !d_attr[1] && d_pred == 2'b10)
      |=> !d_busy);

  assert_d_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_stall != '0) |=> (d_stall == CW'($past(d_stall) - 1'b1)));

  assert_i_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (i_stall != '0) |=> (i_stall == CW'($past(i_stall) - 1'b1)));

  assert_i_cache_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ready && !i_itcm && i_cbit && i_pred == 2'b01) |=> !i_busy);

  assert_d_cache_nostall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_ready && !d_itcm && !d_dtcm && d_attr[1] && d_pred == 2'b01)
      |=> !d_busy);

  assert_d_itcm_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_ready && d_itcm) |=> (d_stall == CW'(PENALTY) && $stable(d_pred)));

  assert_d_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(d_busy) |-> $stable(d_pred));

  assert_i_busy_noready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    i_busy |-> !i_ready);
endmodule

bind region_predictor rp_checker #(.PENALTY(PENALTY)) u_rp_checker (.*);

// File: tb/tb_region_predictor.sv
module tb_region_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PEN = 2;
  localparam int CW = $clog2(PEN + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          i_valid = 1'b0, i_itcm = 1'b0, i_cbit = 1'b0;
  logic          d_valid = 1'b0, d_dtcm = 1'b0, d_itcm = 1'b0;
  logic [1:0]    d_attr = 2'b00;
  logic          i_ready, i_busy, d_ready, d_busy;
  logic [CW-1:0] i_stall, d_stall;
  logic [1:0]    i_pred, d_pred;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  region_predictor #(.PENALTY(PEN)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic d_send(input logic dt, input logic it, input logic [1:0] at);
    d_dtcm = dt; d_itcm = it; d_attr = at; d_valid = 1'b1;
    @(negedge clk);
    d_valid = 1'b0;
  endtask

  task automatic i_send(input logic it, input logic cb);
    i_itcm = it; i_cbit = cb; i_valid = 1'b1;
    @(negedge clk);
    i_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 i_pred", i_pred, 1);
    chk("R1 d_pred", d_pred, 1);
    chk("R1 busy", {i_busy, d_busy}, 0);
    chk("R1 stall", i_stall + d_stall, 0);
  endtask

  task automatic t_wt_wb();
    d_send(1'b0, 1'b0, 2'b10);
    chk("R5 wt match stall", d_stall, 0);
    chk("R5 wt match pred", d_pred, 1);
    d_send(1'b0, 1'b0, 2'b11);
    chk("R6 wb after wt busy", d_busy, 0);
  endtask

  task automatic t_switch();
    d_send(1'b0, 1'b0, 2'b00);
    chk("R4 stall first", d_stall, PEN);
    chk("R4 ready low", d_ready, 0);
    chk("R3 ncnb pred", d_pred, 2);
    @(negedge clk);
    chk("R4 stall second", d_stall, 1);
    chk("R4 busy second", d_busy, 1);
    @(negedge clk);
    chk("R4 stall end", d_stall, 0);
    chk("R4 busy end", d_busy, 0);
    d_send(1'b0, 1'b0, 2'b01);
    chk("R3 ncb same class", d_stall, 0);
  endtask

  task automatic t_ignore();
    d_send(1'b1, 1'b0, 2'b11);
    chk("R3 dtcm pred", d_pred, 0);
    chk("R4 dtcm stall", d_stall, PEN);
    d_send(1'b0, 1'b0, 2'b11);       // presented while busy
    chk("R8 no reload", d_stall, 1);
    @(negedge clk);
    chk("R8 pred kept", d_pred, 0);
    chk("R8 idle after", d_busy, 0);
  endtask

  task automatic t_itcm();
    d_send(1'b0, 1'b1, 2'b11);
    chk("R7 itcm stall", d_stall, PEN);
    chk("R7 itcm pred", d_pred, 0);
    idle(PEN);
    d_send(1'b1, 1'b1, 2'b00);
    chk("R7 repeat stall", d_stall, PEN);
    idle(PEN);
    chk("R7 pred after", d_pred, 0);
  endtask

  task automatic t_inst();
    i_send(1'b0, 1'b1);
    chk("R2 cbit set match", i_stall, 0);
    i_send(1'b0, 1'b0);
    chk("R2 cbit clear stall", i_stall, PEN);
    chk("R2 cbit clear pred", i_pred, 2);
    idle(PEN);
    i_send(1'b1, 1'b1);
    chk("R2 itcm stall", i_stall, PEN);
    chk("R2 itcm pred", i_pred, 0);
    idle(PEN);
    i_send(1'b1, 1'b0);
    chk("R5 itcm match", i_busy, 0);
  endtask

  task automatic t_indep();
    // i_pred is TCM, d_pred is TCM: data goes cacheable (miss), fetch stays TCM (hit)
    i_itcm = 1'b1; i_valid = 1'b1;
    d_send(1'b0, 1'b0, 2'b10);
    i_valid = 1'b0;
    chk("R9 d stalls", d_stall, PEN);
    chk("R9 i no stall", i_stall, 0);
    chk("R9 i ready", i_ready, 1);
    chk("R9 i pred", i_pred, 0);
    idle(PEN);
    i_send(1'b0, 1'b1);
    chk("R9 i stalls", i_stall, PEN);
    chk("R9 d ready", d_ready, 1);
    chk("R9 d pred", d_pred, 1);
    idle(PEN);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wt_wb();
    t_switch();
    t_ignore();
    t_itcm();
    t_inst();
    t_indep();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule